// File: doc/BRIEF.md
# Warm-Init Sequencer with Deferred Interrupt Capture

This block sits beside a processor core and turns a warm initialization request into an ordered restart without the cost of a full power-on reset. When it sees the init line rise, it asks the pipeline to drain and waits for the pipeline to report that it is empty. It then pulses clear strobes for only those state domains that a warm init must wipe, and steers instruction fetch to the fixed restart address. While it does this, it keeps a stall signal high so that fetch logic holds still.

Some state domains survive a warm init but not a reset. These are the cache contents, the floating-point state, the SIMD state, the model-specific registers and the two cache-control bits of the main control register. A parameter mask marks them. A full reset clears every domain. Edge-triggered flush and system-management requests that arrive while the sequence runs are held and then issued once it finishes. A non-maskable interrupt edge that arrives during the sequence is discarded.

Top module: `warm_init_seq`

## Requirements
- R1: While `rst` is high, every bit of `dom_clr_o` is 1 from the next clock edge onward. During that time `busy_o`, `pipe_flush_o`, `fetch_redir_o`, `flush_irq_o`, `smi_irq_o` and `nmi_irq_o` are 0, and `fetch_vec_o` is 0.
- R2: A rising edge of `init_i` sampled while idle raises `pipe_flush_o` on the next cycle. `pipe_flush_o` stays high until a cycle in which `pipe_empty_i` is sampled high, and it drops at the following edge.
- R3: In the cycle after the pipeline reports empty, `dom_clr_o` equals the complement of the preserve mask for exactly one cycle. With the default mask 8'h1F this is 8'hE0: bits 0 to 4 (cache data, floating point, SIMD, model-specific registers, cache-control bits) stay 0, and bits 5 to 7 are 1. Outside that cycle and outside reset, `dom_clr_o` is 0.
- R4: In the cycle after the clear strobe, `fetch_redir_o` is high for exactly one cycle and `fetch_vec_o` carries 32'hFFFF_FFF0. In all other cycles `fetch_vec_o` is 0.
- R5: `busy_o` rises together with `pipe_flush_o`. It stays high through the drain, clear, redirect and release cycles, and falls on the cycle after release.
- R6: A rising edge of `init_i`, or `init_i` held high, while a sequence is active does not restart or lengthen the sequence.
- R7: A rising edge on `flush_req_i` or `smi_req_i` sampled while idle, with no init edge in the same cycle, produces a one-cycle pulse on `flush_irq_o` or `smi_irq_o` on the next cycle.
- R8: Rising edges on `flush_req_i` or `smi_req_i` are held when they are sampled from the init edge through the redirect cycle. Several such edges on one line merge into a single one-cycle pulse, issued in the release cycle. An edge sampled at the start of the release cycle joins that pulse.
- R9: A rising edge on `nmi_req_i` sampled while idle produces a one-cycle `nmi_irq_o` pulse on the next cycle. An edge sampled in the same cycle as the init edge, or at any time up to the start of the release cycle, is discarded.
- R10: `rst` has priority over an active sequence. It returns the block to idle and discards held flush and SMI requests, so that none is issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| init_i | input | 1 | Warm init request level, rising edge starts a sequence |
| flush_req_i | input | 1 | Edge-triggered cache flush request |
| smi_req_i | input | 1 | Edge-triggered system-management interrupt request |
| nmi_req_i | input | 1 | Edge-triggered non-maskable interrupt request |
| pipe_empty_i | input | 1 | Pipeline reports it has drained |
| pipe_flush_o | output | 1 | Drain request to the pipeline |
| fetch_redir_o | output | 1 | One-cycle fetch redirect strobe |
| fetch_vec_o | output | 32 | Redirect target, restart address while redirecting |
| dom_clr_o | output | N_DOM | Per-domain clear strobes |
| busy_o | output | 1 | Sequence in progress, stall fetch |
| flush_irq_o | output | 1 | Flush request pulse to interrupt logic |
| smi_irq_o | output | 1 | SMI pulse to interrupt logic |
| nmi_irq_o | output | 1 | NMI pulse to interrupt logic |

## Verification
The assertions assume that `pipe_empty_i` is returned some time after the drain request. They also assume that every input is a synchronous level that changes only between clock edges, so that a rising edge is seen as one low sample followed by one high sample. The stimulus drives all inputs on the falling clock edge. It raises `pipe_empty_i` with even odds each cycle, so a drain always finishes within a few cycles. Reset is rare in the random phase but does land during active sequences.

// File: rtl/wis_pkg.sv
package wis_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_WIPE    = 3'd2,
    ST_JUMP    = 3'd3,
    ST_RELEASE = 3'd4
  } seq_st_t;

  localparam int unsigned VEC_W = 32;

endpackage

// File: rtl/wis_edge_det.sv
module wis_edge_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic prev_q;

    always_ff @(posedge clk) begin
      prev_q <= lvl_i[g];
    end

    assign rise_o[g] = lvl_i[g] & ~prev_q & ~rst;
  end

endmodule

// File: rtl/wis_seq_fsm.sv
module wis_seq_fsm
  import wis_pkg::*;
#(
  parameter int unsigned          N_DOM         = 8,
  parameter logic [N_DOM-1:0]     PRESERVE_MASK = 8'h1F,
  parameter logic [VEC_W-1:0]     RESTART_VEC   = 32'hFFFF_FFF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_rise_i,
  input  logic             pipe_empty_i,
  output seq_st_t          st_nxt_o,
  output logic             pipe_flush_o,
  output logic             fetch_redir_o,
  output logic [VEC_W-1:0] fetch_vec_o,
  output logic [N_DOM-1:0] dom_clr_o,
  output logic             busy_o
);

  localparam logic [N_DOM-1:0] WARM_CLR = ~PRESERVE_MASK;
  localparam logic [N_DOM-1:0] FULL_CLR = {N_DOM{1'b1}};

  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (init_rise_i) st_d = ST_DRAIN;
      ST_DRAIN:   if (pipe_empty_i) st_d = ST_WIPE;
      ST_WIPE:    st_d = ST_JUMP;
      ST_JUMP:    st_d = ST_RELEASE;
      ST_RELEASE: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (rst) st_d = ST_IDLE;
  end

  assign st_nxt_o = st_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      pipe_flush_o  <= 1'b0;
      fetch_redir_o <= 1'b0;
      fetch_vec_o   <= '0;
      dom_clr_o     <= FULL_CLR;
      busy_o        <= 1'b0;
    end else begin
      st_q          <= st_d;
      pipe_flush_o  <= (st_d == ST_DRAIN);
      fetch_redir_o <= (st_d == ST_JUMP);
      fetch_vec_o   <= (st_d == ST_JUMP) ? RESTART_VEC : '0;
      dom_clr_o     <= (st_d == ST_WIPE) ? WARM_CLR : '0;
      busy_o        <= (st_d != ST_IDLE);
    end
  end

endmodule

// File: rtl/wis_irq_hold.sv
module wis_irq_hold #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_i,
  input  logic         hold_win_i,
  input  logic         release_i,
  output logic [N-1:0] pulse_o
);

  for (genvar g = 0; g < N; g++) begin : g_req
    logic held_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q     <= 1'b0;
        pulse_o[g] <= 1'b0;
      end else if (release_i) begin
        pulse_o[g] <= held_q | rise_i[g];
        held_q     <= 1'b0;
      end else if (hold_win_i) begin
        pulse_o[g] <= 1'b0;
        held_q     <= held_q | rise_i[g];
      end else begin
        pulse_o[g] <= rise_i[g];
        held_q     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/warm_init_seq.sv
module warm_init_seq
  import wis_pkg::*;
#(
  parameter int unsigned      N_DOM         = 8,
  parameter logic [N_DOM-1:0] PRESERVE_MASK = 8'h1F,
  parameter logic [31:0]      RESTART_VEC   = 32'hFFFF_FFF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             flush_req_i,
  input  logic             smi_req_i,
  input  logic             nmi_req_i,
  input  logic             pipe_empty_i,
  output logic             pipe_flush_o,
  output logic             fetch_redir_o,
  output logic [31:0]      fetch_vec_o,
  output logic [N_DOM-1:0] dom_clr_o,
  output logic             busy_o,
  output logic             flush_irq_o,
  output logic             smi_irq_o,
  output logic             nmi_irq_o
);

  localparam int unsigned N_LINES = 4;
  localparam int unsigned N_HELD  = 2;

  logic [N_LINES-1:0] lvl, rise;
  logic [N_HELD-1:0]  held_pulse;
  seq_st_t            st_nxt;
  logic               hold_win, release_now;
  logic               nmi_q;

  assign lvl = {nmi_req_i, smi_req_i, flush_req_i, init_i};

  wis_edge_det #(.W(N_LINES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  wis_seq_fsm #(
    .N_DOM         (N_DOM),
    .PRESERVE_MASK (PRESERVE_MASK),
    .RESTART_VEC   (RESTART_VEC)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .init_rise_i   (rise[0]),
    .pipe_empty_i  (pipe_empty_i),
    .st_nxt_o      (st_nxt),
    .pipe_flush_o  (pipe_flush_o),
    .fetch_redir_o (fetch_redir_o),
    .fetch_vec_o   (fetch_vec_o),
    .dom_clr_o     (dom_clr_o),
    .busy_o        (busy_o)
  );

  assign hold_win    = (st_nxt == ST_DRAIN) || (st_nxt == ST_WIPE) || (st_nxt == ST_JUMP);
  assign release_now = (st_nxt == ST_RELEASE);

  wis_irq_hold #(.N(N_HELD)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise[2:1]),
    .hold_win_i (hold_win),
    .release_i  (release_now),
    .pulse_o    (held_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) nmi_q <= 1'b0;
    else     nmi_q <= rise[3] && (st_nxt == ST_IDLE);
  end

  assign flush_irq_o = held_pulse[0];
  assign smi_irq_o   = held_pulse[1];
  assign nmi_irq_o   = nmi_q;

endmodule

// File: rtl/warm_init_seq_chk.sv
module warm_init_seq_chk #(
  parameter int unsigned      N_DOM         = 8,
  parameter logic [N_DOM-1:0] PRESERVE_MASK = 8'h1F,
  parameter logic [31:0]      RESTART_VEC   = 32'hFFFF_FFF0
) (
  input logic             clk,
  input logic             rst,
  input logic             pipe_empty_i,
  input logic             pipe_flush_o,
  input logic             fetch_redir_o,
  input logic [31:0]      fetch_vec_o,
  input logic [N_DOM-1:0] dom_clr_o,
  input logic             busy_o,
  input logic             flush_irq_o,
  input logic             smi_irq_o,
  input logic             nmi_irq_o
);

  localparam logic [N_DOM-1:0] WARM_CLR = ~PRESERVE_MASK;

  logic rst_d = 1'b1;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_clears_all_R1: assert property (@(posedge clk)
    rst |=> (dom_clr_o == {N_DOM{1'b1}} && !busy_o && !pipe_flush_o && !fetch_redir_o));

  assert_drain_holds_R2: assert property (@(posedge clk) disable iff (rst || rst_d)
    (pipe_flush_o && !pipe_empty_i) |=> pipe_flush_o);

  assert_drain_ends_R2: assert property (@(posedge clk) disable iff (rst || rst_d)
    (pipe_flush_o && pipe_empty_i) |=> (dom_clr_o == WARM_CLR));

  assert_warm_mask_R3: assert property (@(posedge clk) disable iff (rst || rst_d)
    (dom_clr_o != '0) |-> (dom_clr_o == WARM_CLR && busy_o));

  assert_wipe_then_jump_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
    (dom_clr_o != '0) |=> fetch_redir_o);

  assert_vec_value_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
    fetch_redir_o |-> (fetch_vec_o == RESTART_VEC));

  assert_redir_single_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
    fetch_redir_o |=> (!fetch_redir_o && busy_o));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(busy_o) |-> pipe_flush_o);

  assert_release_last_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
    ((flush_irq_o || smi_irq_o) && busy_o) |=> !busy_o);

  assert_nmi_idle_only_R9: assert property (@(posedge clk) disable iff (rst || rst_d)
    nmi_irq_o |-> !busy_o);

endmodule

bind warm_init_seq warm_init_seq_chk #(
  .N_DOM         (N_DOM),
  .PRESERVE_MASK (PRESERVE_MASK),
  .RESTART_VEC   (RESTART_VEC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .pipe_empty_i  (pipe_empty_i),
  .pipe_flush_o  (pipe_flush_o),
  .fetch_redir_o (fetch_redir_o),
  .fetch_vec_o   (fetch_vec_o),
  .dom_clr_o     (dom_clr_o),
  .busy_o        (busy_o),
  .flush_irq_o   (flush_irq_o),
  .smi_irq_o     (smi_irq_o),
  .nmi_irq_o     (nmi_irq_o)
);

// File: tb/tb_warm_init_seq.sv
module tb_warm_init_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_i = 1'b0, flush_req_i = 1'b0, smi_req_i = 1'b0, nmi_req_i = 1'b0;
  logic pipe_empty_i = 1'b0;
  logic        pipe_flush_o, fetch_redir_o, busy_o;
  logic [31:0] fetch_vec_o;
  logic [7:0]  dom_clr_o;
  logic        flush_irq_o, smi_irq_o, nmi_irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  warm_init_seq dut (
    .clk(clk), .rst(rst), .init_i(init_i), .flush_req_i(flush_req_i),
    .smi_req_i(smi_req_i), .nmi_req_i(nmi_req_i), .pipe_empty_i(pipe_empty_i),
    .pipe_flush_o(pipe_flush_o), .fetch_redir_o(fetch_redir_o),
    .fetch_vec_o(fetch_vec_o), .dom_clr_o(dom_clr_o), .busy_o(busy_o),
    .flush_irq_o(flush_irq_o), .smi_irq_o(smi_irq_o), .nmi_irq_o(nmi_irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench-side expectation, built from the requirements
  int         ph = 0;
  logic [3:0] mprev = 4'b0;
  logic       hold_f = 1'b0, hold_s = 1'b0;
  logic       e_flush = 1'b0, e_redir = 1'b0, e_busy = 1'b0;
  logic       e_firq = 1'b0, e_sirq = 1'b0, e_nirq = 1'b0;
  logic [7:0] e_clr = 8'h00;
  logic [31:0] e_vec = 32'h0;

  function automatic int next_phase(int p, logic init_rise, logic empty);
    case (p)
      0: return init_rise ? 1 : 0;
      1: return empty ? 2 : 1;
      2: return 3;
      3: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    logic [3:0] cur, rs;
    int np;
    bit win, rel;
    cur = {nmi_req_i, smi_req_i, flush_req_i, init_i};
    rs = cur & ~mprev;
    mprev = cur;
    if (rst) begin
      ph = 0; hold_f = 0; hold_s = 0;
      e_clr = 8'hFF; e_flush = 0; e_redir = 0; e_vec = 0; e_busy = 0;
      e_firq = 0; e_sirq = 0; e_nirq = 0;
    end else begin
      np  = next_phase(ph, rs[0], pipe_empty_i);
      win = (np >= 1 && np <= 3);
      rel = (np == 4);
      e_firq = rel ? (hold_f | rs[1]) : (win ? 1'b0 : rs[1]);
      e_sirq = rel ? (hold_s | rs[2]) : (win ? 1'b0 : rs[2]);
      hold_f = win ? (hold_f | rs[1]) : 1'b0;
      hold_s = win ? (hold_s | rs[2]) : 1'b0;
      e_nirq = rs[3] && (np == 0);
      e_flush = (np == 1);
      e_clr   = (np == 2) ? 8'hE0 : 8'h00;
      e_redir = (np == 3);
      e_vec   = (np == 3) ? 32'hFFFF_FFF0 : 32'h0;
      e_busy  = (np != 0);
      ph = np;
    end
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(32'(dom_clr_o), 32'(e_clr), (e_clr == 8'hFF) ? "R1 dom_clr" : "R3 dom_clr");
    chk(32'(pipe_flush_o), 32'(e_flush), "R2 pipe_flush");
    chk(32'(fetch_redir_o), 32'(e_redir), "R4 redirect");
    chk(fetch_vec_o, e_vec, "R4 vector");
    chk(32'(busy_o), 32'(e_busy), "R5 busy");
    chk(32'(flush_irq_o), 32'(e_firq), "R7/R8 flush_irq");
    chk(32'(smi_irq_o), 32'(e_sirq), "R7/R8 smi_irq");
    chk(32'(nmi_irq_o), 32'(e_nirq), "R9 nmi_irq");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(logic r, logic in, logic f, logic s, logic n, logic pe);
    rst = r; init_i = in; flush_req_i = f; smi_req_i = s; nmi_req_i = n; pipe_empty_i = pe;
    cyc();
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);
    // R1: reset state
    repeat (3) drive(1, 0, 0, 0, 0, 0);
    chk(32'(dom_clr_o), 32'hFF, "R1 all domains cleared in reset");
    drive(0, 0, 0, 0, 0, 0);

    // R7, R9: idle edges pass straight through
    drive(0, 0, 1, 0, 1, 0);
    chk(32'(flush_irq_o), 1, "R7 idle flush pulse");
    chk(32'(nmi_irq_o), 1, "R9 idle nmi pulse");
    drive(0, 0, 0, 1, 0, 0);
    chk(32'(smi_irq_o), 1, "R7 idle smi pulse");
    drive(0, 0, 0, 0, 0, 0);

    // R2, R8, R9: init with SMI and NMI edges coincident, slow drain
    drive(0, 1, 0, 1, 1, 0);
    chk(32'(pipe_flush_o), 1, "R2 flush after init edge");
    chk(32'(nmi_irq_o), 0, "R9 coincident nmi dropped");
    drive(0, 1, 1, 0, 0, 0);
    drive(0, 1, 0, 0, 1, 0);
    drive(0, 1, 1, 0, 0, 0);
    chk(32'(pipe_flush_o), 1, "R2 flush held while not empty");
    drive(0, 1, 0, 0, 0, 1);
    chk(32'(dom_clr_o), 32'hE0, "R3 warm clear mask");
    drive(0, 1, 0, 0, 0, 0);
    chk(fetch_vec_o, 32'hFFFF_FFF0, "R4 restart vector");
    drive(0, 1, 0, 0, 0, 0);
    chk(32'(flush_irq_o), 1, "R8 merged flush at release");
    chk(32'(smi_irq_o), 1, "R8 held smi at release");
    chk(32'(busy_o), 1, "R5 busy in release");
    drive(0, 0, 0, 0, 0, 0);
    chk(32'(busy_o), 0, "R5 busy drops after release");
    chk(32'(flush_irq_o), 0, "R8 single pulse");

    // R6: re-init edge during an active sequence is ignored
    drive(0, 1, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 1, 0, 0, 0, 1);
    drive(0, 1, 0, 0, 0, 1);
    drive(0, 1, 0, 0, 0, 1);
    chk(32'(busy_o), 0, "R6 sequence not extended by re-init");
    drive(0, 0, 0, 0, 0, 1);
    chk(32'(busy_o), 0, "R6 no restart");

    // R10: reset aborts sequence and discards held flush
    drive(0, 1, 0, 0, 0, 0);
    drive(0, 1, 1, 0, 0, 0);
    drive(1, 1, 1, 0, 0, 0);
    for (int k = 0; k < 5; k++) begin
      drive(0, 1, 1, 0, 0, 1);
      chk(32'(flush_irq_o), 0, "R10 held flush discarded");
      chk(32'(busy_o), 0, "R10 idle after reset");
    end
    drive(0, 0, 0, 0, 0, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 60) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0,
            ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule